// File: doc/BRIEF.md
# Byte-Wide Converter Register Interface

This block is the host-facing register file of a 12-bit data converter that hangs on an 8-bit parallel bus. A host moves 16-bit words through it as byte pairs, using an active-low chip select, read strobe and write strobe. The bus is split into an input byte, an output byte and an output enable, which together form the bidirectional data pins. Strobes are sampled by the block clock, and a transfer completes on the clock cycle in which its strobe is seen high again after being low.

Each written word carries its own destination in its two top bits. Reads work differently: a persistent read-select field inside the control register picks the source. With no writes at all, reads return conversion results, so the block behaves as a read-only converter. A bank of ten calibration registers sits behind a calibration-select field. A shared index walks through the chosen group on successive calibration accesses.

The converter core supplies the conversion result and the status word. The block hands the control, test and calibration contents back to the core.

Top module: `conv_regif`

## Requirements
- R1: A write completes as two byte transfers with chip select low: low byte (word bits 7:0) first, then high byte (bits 15:8). Each byte is the input bus value in the last cycle its write strobe was low. The assembled word takes effect two clock edges after the cycle in which the second strobe rises.
- R2: Word bits 15:14 pick the target: 01 test, 10 calibration bank, 11 control. Only bits 13:0 are stored. Code 00 changes no register.
- R3: The control register cannot be read back, and ctrl_out shows its 14 stored bits. Control bits 7:6 choose the read source: 00 conversion result, 01 test, 10 calibration, 11 status.
- R4: After reset the control, test and calibration registers are zero, both byte-phase flags are clear, and reads return the conversion result.
- R5: A read of the conversion result returns the 12-bit result in bits 11:0, with bits 15:12 zero.
- R6: The read source stays the same across any number of reads and writes to other registers, until the control register is rewritten.
- R7: A read is two byte transfers: low byte first, then high byte. The high byte comes from a copy of the whole source word, taken when the first byte completes.
- R8: Control bits 9:8 choose a calibration group within bank indices 0 to 9: 00 indices 0 to 9, 01 indices 0 to 1, 10 index 1 only, 11 index 0 only. A control write moves the shared index to the first index of its group. Each calibration word write, and each completed two-byte calibration read, steps the index by one, wrapping to the start of the group after its last index.
- R9: Strobes given while chip select is high change no register and no byte phase.
- R10: The output bus is enabled only while chip select and read strobe are both low.
- R11: A status read returns the 16-bit status input. A test read returns the test register in bits 13:0, with bits 15:14 zero.
- R12: A calibration read returns the indexed register in bits 13:0, with bits 15:14 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Byte driven by the host |
| bus_out | output | 8 | Byte returned to the host |
| bus_oe | output | 1 | Output enable for bus_out |
| result_in | input | 12 | Latest conversion result from the core |
| status_in | input | 16 | Status word from the core |
| ctrl_out | output | 14 | Stored control register |
| test_out | output | 14 | Stored test register |
| cal_out | output | 140 | Ten calibration registers, index i at bits 14*i+13:14*i |

## Verification
Several properties are checked on every cycle. The output enable is tied to chip select and read strobe. The control and test registers change only two edges after a completed write strobe under chip select. The read phase flips only on a completed read strobe. The reset values appear after reset. The low byte of a result read mirrors the result input. Other behaviour can only be shown by the bench's scenarios: the address decode, the discarded 00 words, read-source persistence, snapshot timing of the high byte, and the index walk through each calibration group with its wrap.

// File: rtl/conv_regif_pkg.sv
package conv_regif_pkg;

    localparam int BUS_W     = 8;
    localparam int WORD_W    = 2 * BUS_W;
    localparam int REG_W     = WORD_W - 2;
    localparam int CAL_N     = 10;
    localparam int CAL_IDX_W = $clog2(CAL_N);
    localparam int RDSEL_LSB = 6;
    localparam int CSEL_LSB  = 8;

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_TEST = 2'b01,
        TGT_CAL  = 2'b10,
        TGT_CTRL = 2'b11
    } wr_tgt_e;

    typedef enum logic [1:0] {
        SRC_RESULT = 2'b00,
        SRC_TEST   = 2'b01,
        SRC_CAL    = 2'b10,
        SRC_STATUS = 2'b11
    } rd_src_e;

    typedef struct packed {
        wr_tgt_e            tgt;
        logic [REG_W-1:0]   payload;
    } wr_word_t;

    typedef logic [CAL_IDX_W-1:0] cal_idx_t;

    function automatic cal_idx_t grp_first(input logic [1:0] csel);
        case (csel)
            2'b10:   grp_first = cal_idx_t'(1);
            default: grp_first = cal_idx_t'(0);
        endcase
    endfunction

    function automatic cal_idx_t grp_last(input logic [1:0] csel);
        case (csel)
            2'b00:   grp_last = cal_idx_t'(CAL_N - 1);
            2'b01:   grp_last = cal_idx_t'(1);
            2'b10:   grp_last = cal_idx_t'(1);
            default: grp_last = cal_idx_t'(0);
        endcase
    endfunction

    function automatic cal_idx_t grp_step(input cal_idx_t idx, input logic [1:0] csel);
        if (idx >= grp_last(csel))
            grp_step = grp_first(csel);
        else
            grp_step = idx + cal_idx_t'(1);
    endfunction

endpackage

// File: rtl/regif_byte_seq.sv
module regif_byte_seq
    import conv_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [BUS_W-1:0]  bus_in,
    output logic              wr_phase,
    output logic              rd_phase,
    output logic              word_vld,
    output wr_word_t          word,
    output logic              rd_lo_done,
    output logic              rd_hi_done
);
    logic             wr_q, rd_q;
    logic [BUS_W-1:0] cur_byte, lo_byte;
    logic             wr_rise, rd_rise;

    assign wr_rise    = !cs_n && wr_n && !wr_q;
    assign rd_rise    = !cs_n && rd_n && !rd_q;
    assign rd_lo_done = rd_rise && !rd_phase;
    assign rd_hi_done = rd_rise &&  rd_phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_byte <= '0;
        else if (!cs_n && !wr_n)
            cur_byte <= bus_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_phase <= 1'b0;
            lo_byte  <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (wr_rise) begin
                if (!wr_phase) begin
                    lo_byte  <= cur_byte;
                    wr_phase <= 1'b1;
                end else begin
                    word     <= wr_word_t'({cur_byte, lo_byte});
                    word_vld <= 1'b1;
                    wr_phase <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_phase <= 1'b0;
        else if (rd_rise)
            rd_phase <= !rd_phase;
    end

endmodule

// File: rtl/regif_regbank.sv
module regif_regbank
    import conv_regif_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           word_vld,
    input  wr_word_t                       word,
    input  logic                           rd_hi_done,
    output logic [REG_W-1:0]               ctrl_q,
    output logic [REG_W-1:0]               test_q,
    output logic [CAL_N-1:0][REG_W-1:0]    cal_q,
    output cal_idx_t                       cal_idx
);
    logic    [1:0] csel;
    rd_src_e       rsel;
    logic          wr_test, wr_cal, wr_ctrl, cal_rd_step;

    assign csel        = ctrl_q[CSEL_LSB +: 2];
    assign rsel        = rd_src_e'(ctrl_q[RDSEL_LSB +: 2]);
    assign wr_test     = word_vld && (word.tgt == TGT_TEST);
    assign wr_cal      = word_vld && (word.tgt == TGT_CAL);
    assign wr_ctrl     = word_vld && (word.tgt == TGT_CTRL);
    assign cal_rd_step = rd_hi_done && (rsel == SRC_CAL);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= word.payload;
    end

    always_ff @(posedge clk) begin
        if (rst)
            test_q <= '0;
        else if (wr_test)
            test_q <= word.payload;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cal_idx <= '0;
        else if (wr_ctrl)
            cal_idx <= grp_first(word.payload[CSEL_LSB +: 2]);
        else if (wr_cal || cal_rd_step)
            cal_idx <= grp_step(cal_idx, csel);
    end

    for (genvar i = 0; i < CAL_N; i++) begin : g_cal
        always_ff @(posedge clk) begin
            if (rst)
                cal_q[i] <= '0;
            else if (wr_cal && (cal_idx == cal_idx_t'(i)))
                cal_q[i] <= word.payload;
        end
    end

endmodule

// File: rtl/regif_rdmux.sv
module regif_rdmux
    import conv_regif_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int STAT_W = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cs_n,
    input  logic                           rd_n,
    input  logic                           rd_phase,
    input  logic                           rd_lo_done,
    input  logic [REG_W-1:0]               ctrl_q,
    input  logic [REG_W-1:0]               test_q,
    input  logic [CAL_N-1:0][REG_W-1:0]    cal_q,
    input  cal_idx_t                       cal_idx,
    input  logic [RES_W-1:0]               result_in,
    input  logic [STAT_W-1:0]              status_in,
    output logic [BUS_W-1:0]               bus_out,
    output logic                           bus_oe
);
    localparam int RES_PAD  = WORD_W - RES_W;
    localparam int REG_PAD  = WORD_W - REG_W;

    logic [WORD_W-1:0] src_word, snap;
    rd_src_e           rsel;

    assign rsel = rd_src_e'(ctrl_q[RDSEL_LSB +: 2]);

    always_comb begin
        case (rsel)
            SRC_RESULT: src_word = {{RES_PAD{1'b0}}, result_in};
            SRC_TEST:   src_word = {{REG_PAD{1'b0}}, test_q};
            SRC_CAL:    src_word = {{REG_PAD{1'b0}}, cal_q[cal_idx]};
            default:    src_word = WORD_W'(status_in);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            snap <= '0;
        else if (rd_lo_done)
            snap <= src_word;
    end

    assign bus_out = rd_phase ? snap[WORD_W-1:BUS_W] : src_word[BUS_W-1:0];
    assign bus_oe  = !cs_n && !rd_n;

endmodule

// File: rtl/conv_regif.sv
module conv_regif
    import conv_regif_pkg::*;
#(
    parameter int RES_W  = 12,
    parameter int STAT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_n,
    input  logic                      rd_n,
    input  logic                      wr_n,
    input  logic [BUS_W-1:0]          bus_in,
    output logic [BUS_W-1:0]          bus_out,
    output logic                      bus_oe,
    input  logic [RES_W-1:0]          result_in,
    input  logic [STAT_W-1:0]         status_in,
    output logic [REG_W-1:0]          ctrl_out,
    output logic [REG_W-1:0]          test_out,
    output logic [CAL_N*REG_W-1:0]    cal_out
);
    logic                         wr_phase, rd_phase, word_vld;
    logic                         rd_lo_done, rd_hi_done;
    wr_word_t                     word;
    logic [CAL_N-1:0][REG_W-1:0]  cal_q;
    cal_idx_t                     cal_idx;

    regif_byte_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .bus_in     (bus_in),
        .wr_phase   (wr_phase),
        .rd_phase   (rd_phase),
        .word_vld   (word_vld),
        .word       (word),
        .rd_lo_done (rd_lo_done),
        .rd_hi_done (rd_hi_done)
    );

    regif_regbank u_bank (
        .clk        (clk),
        .rst        (rst),
        .word_vld   (word_vld),
        .word       (word),
        .rd_hi_done (rd_hi_done),
        .ctrl_q     (ctrl_out),
        .test_q     (test_out),
        .cal_q      (cal_q),
        .cal_idx    (cal_idx)
    );

    regif_rdmux #(.RES_W(RES_W), .STAT_W(STAT_W)) u_mux (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .rd_phase   (rd_phase),
        .rd_lo_done (rd_lo_done),
        .ctrl_q     (ctrl_out),
        .test_q     (test_out),
        .cal_q      (cal_q),
        .cal_idx    (cal_idx),
        .result_in  (result_in),
        .status_in  (status_in),
        .bus_out    (bus_out),
        .bus_oe     (bus_oe)
    );

    assign cal_out = cal_q;

endmodule

// File: rtl/conv_regif_chk.sv
module conv_regif_chk
    import conv_regif_pkg::*;
#(
    parameter int RES_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [BUS_W-1:0]  bus_out,
    input logic              bus_oe,
    input logic [RES_W-1:0]  result_in,
    input logic [REG_W-1:0]  ctrl_out,
    input logic [REG_W-1:0]  test_out,
    input logic              rd_phase,
    input logic              wr_phase
);
    logic mon_wr_q, mon_rd_q, mon_wr_rise, mon_rd_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            mon_wr_q <= 1'b1;
            mon_rd_q <= 1'b1;
        end else begin
            mon_wr_q <= wr_n;
            mon_rd_q <= rd_n;
        end
    end

    assign mon_wr_rise = !cs_n && wr_n && !mon_wr_q;
    assign mon_rd_rise = !cs_n && rd_n && !mon_rd_q;

    // R10
    bus_oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!cs_n && !rd_n));

    // R1
    ctrl_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_out) |-> $past(mon_wr_rise, 2));

    // R9
    test_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(test_out) |-> $past(mon_wr_rise, 2));

    // R7
    rd_phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_phase) |-> $past(mon_rd_rise));

    // R4
    reset_value_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_out == '0 && test_out == '0 && !rd_phase && !wr_phase));

    // R5
    result_low_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !rd_phase && ctrl_out[RDSEL_LSB +: 2] == 2'b00)
            |-> (bus_out == result_in[BUS_W-1:0]));

endmodule

bind conv_regif conv_regif_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .result_in (result_in),
    .ctrl_out  (ctrl_out),
    .test_out  (test_out),
    .rd_phase  (rd_phase),
    .wr_phase  (wr_phase)
);

// File: tb/conv_regif_bench.sv
module conv_regif_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]   bus_in = '0;
    logic [7:0]   bus_out;
    logic         bus_oe;
    logic [11:0]  result_in = 12'hF7E;
    logic [15:0]  status_in = 16'hA5C3;
    logic [13:0]  ctrl_out, test_out;
    logic [139:0] cal_out;

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    always #5 clk = !clk;

    conv_regif u_conv_regif (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .result_in(result_in), .status_in(status_in),
        .ctrl_out(ctrl_out), .test_out(test_out), .cal_out(cal_out)
    );

    typedef struct packed {
        logic [15:0] wr_w;
        logic [15:0] ctl_w;
        logic [15:0] exp_w;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'h5234, 16'hC040, 16'h1234},
        '{16'h7FFF, 16'hC040, 16'h3FFF},
        '{16'h0ABC, 16'hC040, 16'h3FFF},
        '{16'h0000, 16'hC0C0, 16'hA5C3},
        '{16'h0000, 16'hC000, 16'h0F7E}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); bus_in = b; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] w);
        @(negedge clk); cs_n = 1'b0;
        wr_byte(w[7:0]);
        wr_byte(w[15:8]);
        cs_n = 1'b1;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); b = bus_out;
        rd_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_word(output logic [15:0] w);
        logic [7:0] lo, hi;
        @(negedge clk); cs_n = 1'b0;
        rd_byte(lo);
        rd_byte(hi);
        cs_n = 1'b1;
        w = {hi, lo};
    endtask

    function automatic logic [13:0] cal_at(input int i);
        return cal_out[i*14 +: 14];
    endfunction

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rw;
        logic [7:0]  lo, hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R4 reset state
        chk("R4 ctrl", ctrl_out, 14'h0);
        chk("R4 test", test_out, 14'h0);
        chk("R10 idle oe", bus_oe, 1'b0);
        read_word(rw);
        chk("R4 R5 default result read", rw, 16'h0F7E);

        // table of write / select / read-back vectors (R2 R3 R6 R11 R5)
        for (int k = 0; k < 5; k++) begin
            write_word(VECS[k].wr_w);
            write_word(VECS[k].ctl_w);
            read_word(rw);
            chk($sformatf("R2 R3 R11 vector %0d", k), rw, VECS[k].exp_w);
        end
        chk("R3 ctrl_out", ctrl_out, 14'h0000);

        // R6 select persists across other writes
        write_word(16'hC040);
        write_word(16'h4155);
        read_word(rw);
        chk("R6 test read 1", rw, 16'h0155);
        write_word(16'h42AA);
        read_word(rw);
        chk("R6 test read 2", rw, 16'h02AA);
        chk("R3 ctrl shows select", ctrl_out, 14'h0040);

        // R9 strobes with chip select high
        @(negedge clk); bus_in = 8'h11; wr_n = 1'b0;
        repeat (2) @(negedge clk); wr_n = 1'b1;
        @(negedge clk); bus_in = 8'h7F; wr_n = 1'b0;
        repeat (2) @(negedge clk); wr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 test unchanged", test_out, 14'h02AA);
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk);
        chk("R10 oe with cs high", bus_oe, 1'b0);
        rd_n = 1'b1;
        repeat (2) @(negedge clk);
        write_word(16'h4033);
        chk("R9 R1 phase intact", test_out, 14'h0033);

        // R7 snapshot of high byte
        write_word(16'hC000);
        @(negedge clk); cs_n = 1'b0;
        rd_byte(lo);
        chk("R5 R10 low byte", lo, 8'h7E);
        result_in = 12'h123;
        rd_byte(hi);
        cs_n = 1'b1;
        chk("R7 high from snapshot", hi, 8'h0F);
        read_word(rw);
        chk("R5 new result", rw, 16'h0123);

        // R8 R12 full group walk
        write_word(16'hC080);
        for (int i = 0; i < 10; i++)
            write_word(16'h8000 | (16'h0A00 + i * 16'h0111));
        for (int i = 0; i < 10; i++) begin
            read_word(rw);
            chk($sformatf("R8 R12 cal read %0d", i), rw, 16'h0A00 + i * 16'h0111);
        end
        read_word(rw);
        chk("R8 wrap read", rw, 16'h0A00);

        write_word(16'hC180);
        write_word(16'h9111);
        write_word(16'hA222);
        write_word(16'h8333);
        chk("R8 pair idx0", cal_at(0), 14'h0333);
        chk("R8 pair idx1", cal_at(1), 14'h2222);

        write_word(16'hC280);
        write_word(16'h8444);
        write_word(16'h8445);
        chk("R8 offset only", cal_at(1), 14'h0445);
        chk("R8 offset keeps idx0", cal_at(0), 14'h0333);

        write_word(16'hC380);
        write_word(16'h8555);
        write_word(16'h8556);
        chk("R8 gain only", cal_at(0), 14'h0556);
        chk("R8 idx2 untouched", cal_at(2), 14'h0C22);
        read_word(rw);
        chk("R12 gain read", rw, 16'h0556);

        // R1 ordering: low byte first
        write_word(16'h7ABC);
        chk("R1 byte order", test_out, 14'h3ABC);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule